// File: doc/BRIEF.md
# Virtual Task-Priority Threshold Monitor

This block keeps a guest's virtual task-priority byte in a shadow register. It watches every write to that byte, for example one that comes from a move to the priority control register. A 32-bit threshold register sits beside it. Only the low four bits of the threshold take part in any decision, and they set a floor for the priority class, which is the upper nibble of the byte.

When a write leaves the priority class under that floor, the block raises a one-cycle trap request so that the hypervisor can step in. This only happens while the shadow control is on and virtual-interrupt delivery is off. Reads of the priority always return the current shadow value. Software can read the threshold back in full.

Top module: `vtpr_monitor`

## Requirements
- R1: After reset, `prio_rd_data` is 0x00, `thr_rd_data` is 0x00000000 and `trap_req` is 0.
- R2: A write with `prio_wr_en`=1 and `shadow_en`=1 makes `prio_rd_data` equal to the written byte from the next cycle on.
- R3: A priority write made while `shadow_en`=0 leaves `prio_rd_data` unchanged and raises no trap.
- R4: An accepted priority write whose bits 7:4 are numerically less than threshold bits 3:0 drives `trap_req` to 1 in the cycle after the write, provided `vid_en` was 0 in the write cycle.
- R5: An accepted write whose bits 7:4 are equal to or greater than threshold bits 3:0 raises no trap.
- R6: While `vid_en`=1 in the write cycle, no priority write raises a trap.
- R7: A threshold write makes `thr_rd_data` equal to all 32 written bits in the next cycle. Bits 31:4 have no effect on trapping.
- R8: When a threshold write and a priority write fall in the same cycle, the priority is compared against the newly written threshold bits 3:0.
- R9: Each trap pulse lasts one cycle per triggering write. A cycle that has no triggering write in the cycle before it has `trap_req`=0, and back-to-back writes are judged each on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shadow_en | input | 1 | Priority-shadow control; enables the monitor |
| vid_en | input | 1 | Virtual-interrupt delivery control; suppresses traps when 1 |
| prio_wr_en | input | 1 | Priority write strobe |
| prio_wr_data | input | 8 | Priority byte to write |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 32 | Threshold word to write |
| prio_rd_data | output | 8 | Current shadow priority |
| thr_rd_data | output | 32 | Current threshold word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
A threshold update and a priority write can fall in the same cycle, and the trap decision then hinges on which threshold applies. The bench provokes this in two ways. In one case the new threshold turns a write that would otherwise be harmless into a trap. In the other it clears a write that would otherwise trap. A behavioural reference model, which applies the new threshold, judges `trap_req` one cycle later. The bench also places trapping writes in consecutive cycles so that it can show the pulses are judged one write at a time.

// File: rtl/vtpr_pkg.sv
package vtpr_pkg;
  localparam int PRIO_W  = 8;
  localparam int CLASS_W = 4;
  localparam int THR_W   = 32;

  typedef logic [PRIO_W-1:0]  prio_t;
  typedef logic [CLASS_W-1:0] class_t;
  typedef logic [THR_W-1:0]   thr_t;

  function automatic class_t prio_class(input prio_t p);
    return p[PRIO_W-1 -: CLASS_W];
  endfunction

  function automatic class_t thr_floor(input thr_t t);
    return t[CLASS_W-1:0];
  endfunction

  function automatic logic class_below(input prio_t p, input thr_t t);
    return prio_class(p) < thr_floor(t);
  endfunction
endpackage

// File: rtl/vtpr_shadow_reg.sv
module vtpr_shadow_reg
  import vtpr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  prio_t din,
  output prio_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/vtpr_thresh_reg.sv
module vtpr_thresh_reg
  import vtpr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  thr_t din,
  output thr_t q,
  output thr_t eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
  // threshold seen by a priority write in this cycle: the incoming word wins
  assign eff = load ? din : q;
endmodule

// File: rtl/vtpr_trap_gen.sv
module vtpr_trap_gen
  import vtpr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  vid_en,
  input  prio_t new_prio,
  input  thr_t  eff_thr,
  output logic  trap_cond,
  output logic  trap_q
);
  assign trap_cond = accept && !vid_en && class_below(new_prio, eff_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_cond;
  end
endmodule

// File: rtl/vtpr_monitor.sv
module vtpr_monitor
  import vtpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shadow_en,
  input  logic              vid_en,
  input  logic              prio_wr_en,
  input  logic [PRIO_W-1:0] prio_wr_data,
  input  logic              thr_wr_en,
  input  logic [THR_W-1:0]  thr_wr_data,
  output logic [PRIO_W-1:0] prio_rd_data,
  output logic [THR_W-1:0]  thr_rd_data,
  output logic              trap_req
);
  logic prio_accept;
  logic trap_cond;
  thr_t eff_thr;

  assign prio_accept = prio_wr_en && shadow_en;

  vtpr_shadow_reg u_shadow (
    .clk(clk), .rst_n(rst_n), .load(prio_accept),
    .din(prio_wr_data), .q(prio_rd_data)
  );

  vtpr_thresh_reg u_thresh (
    .clk(clk), .rst_n(rst_n), .load(thr_wr_en),
    .din(thr_wr_data), .q(thr_rd_data), .eff(eff_thr)
  );

  vtpr_trap_gen u_trap (
    .clk(clk), .rst_n(rst_n), .accept(prio_accept), .vid_en(vid_en),
    .new_prio(prio_wr_data), .eff_thr(eff_thr),
    .trap_cond(trap_cond), .trap_q(trap_req)
  );
endmodule

// File: rtl/vtpr_monitor_chk.sv
module vtpr_monitor_chk
  import vtpr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        shadow_en,
  input logic        vid_en,
  input logic        prio_wr_en,
  input prio_t       prio_wr_data,
  input logic        thr_wr_en,
  input thr_t        thr_wr_data,
  input prio_t       prio_rd_data,
  input thr_t        thr_rd_data,
  input logic        trap_req
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_wr_en && shadow_en) |=> prio_rd_data == $past(prio_wr_data));

  a_r3_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(prio_wr_en && shadow_en) |=> $stable(prio_rd_data));

  a_r6_vid_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
    vid_en |=> !trap_req);

  a_r7_thr_readback: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_en |=> thr_rd_data == $past(thr_wr_data));

  a_r9_trap_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(prio_wr_en && shadow_en) |=> !trap_req);

  a_r5_high_class_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_wr_en && !thr_wr_en && prio_wr_data[7:4] >= thr_rd_data[3:0]) |=> !trap_req);
endmodule

bind vtpr_monitor vtpr_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shadow_en(shadow_en), .vid_en(vid_en),
  .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data),
  .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
  .prio_rd_data(prio_rd_data), .thr_rd_data(thr_rd_data), .trap_req(trap_req)
);

// File: tb/vtpr_monitor_tb.sv
module vtpr_monitor_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shadow_en = 1'b0, vid_en = 1'b0;
  logic        prio_wr_en = 1'b0, thr_wr_en = 1'b0;
  logic [7:0]  prio_wr_data = '0;
  logic [31:0] thr_wr_data = '0;
  logic [7:0]  prio_rd_data;
  logic [31:0] thr_rd_data;
  logic        trap_req;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_prio = 0;
  longint m_thr = 0;
  bit m_trap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtpr_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .shadow_en(shadow_en), .vid_en(vid_en),
    .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .prio_rd_data(prio_rd_data), .thr_rd_data(thr_rd_data), .trap_req(trap_req)
  );

  task automatic check(string req);
    tests += 3;
    if (prio_rd_data !== 8'(m_prio)) begin
      fails++; $display("FAIL %s prio_rd_data act=%h exp=%h", req, prio_rd_data, 8'(m_prio));
    end
    if (thr_rd_data !== 32'(m_thr)) begin
      fails++; $display("FAIL %s thr_rd_data act=%h exp=%h", req, thr_rd_data, 32'(m_thr));
    end
    if (trap_req !== m_trap) begin
      fails++; $display("FAIL %s trap_req act=%b exp=%b", req, trap_req, m_trap);
    end
  endtask

  // one cycle: drive at negedge, model steps at posedge, compare at next negedge
  task automatic step(string req, bit se, bit vid, bit pw, int pd, bit tw, longint td);
    int floor_v;
    shadow_en = se; vid_en = vid; prio_wr_en = pw; prio_wr_data = 8'(pd);
    thr_wr_en = tw; thr_wr_data = 32'(td);
    @(posedge clk);
    floor_v = tw ? int'(td % 16) : int'(m_thr % 16);
    m_trap = pw && se && !vid && ((pd / 16) < floor_v);
    if (pw && se) m_prio = pd % 256;
    if (tw) m_thr = td;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1ns);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R7: full word read back; upper bits junk, floor = 5
    step("R7", 1, 0, 0, 0, 1, 64'hDEAD_BEE5);
    // R2: accepted write, class 9 >= 5, no trap (R5)
    step("R2", 1, 0, 1, 8'h93, 0, 0);
    step("R5", 1, 0, 1, 8'h50, 0, 0);
    // R4: class 4 < 5 traps next cycle
    step("R4", 1, 0, 1, 8'h4F, 0, 0);
    step("R9", 1, 0, 0, 0, 0, 0);
    // R3: shadow disabled, low value ignored
    step("R3", 0, 0, 1, 8'h01, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0);
    // R6: vid on, low write updates but no trap
    step("R6", 1, 1, 1, 8'h12, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 0);
    // R9: back-to-back trapping writes, then a harmless one
    step("R9", 1, 0, 1, 8'h20, 0, 0);
    step("R9", 1, 0, 1, 8'h30, 0, 0);
    step("R9", 1, 0, 1, 8'hF0, 0, 0);
    step("R9", 1, 0, 0, 0, 0, 0);
    // R7: upper threshold bits high, floor 0 -> class 0 no trap
    step("R7", 1, 0, 0, 0, 1, 64'hFFFF_FFF0);
    step("R7", 1, 0, 1, 8'h00, 0, 0);
    // R8: same-cycle threshold raises floor, write traps
    step("R8", 1, 0, 1, 8'h70, 1, 64'h0000_0008);
    step("R8", 1, 0, 0, 0, 0, 0);
    // R8: same-cycle threshold lowers floor, write would trap under old
    step("R8", 1, 0, 1, 8'h30, 1, 64'h1234_5672);
    step("R8", 1, 0, 0, 0, 0, 0);
    // R5 boundary: class equal to floor
    step("R5", 1, 0, 1, 8'h2A, 0, 0);
    // R4 boundary: floor 15, class 14
    step("R4", 1, 0, 0, 0, 1, 64'h0000_000F);
    step("R4", 1, 0, 1, 8'hEF, 0, 0);
    step("R9", 1, 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule